// File: doc/BRIEF.md
# Configurable-Endian Host Register Port

This block sits between an external host data bus and a small internal register file. The host bus is 32 bits wide on the pins, but only 8, 16 or 32 of those bits are active at a time. A byte-wide configuration register selects the active width. A strap input, captured while reset is held, picks the byte order:

- With little endian order, the active lanes grow upward from bits 7:0.
- With big endian order, the active lanes grow downward from bits 31:24.

The port maps each register byte onto its lane for both writes and reads. Registers are one, two or four bytes wide. When the port is narrower than a register, the host reaches the register through several accesses. Each access covers an aligned group of bytes chosen by the low address bits. Lanes that carry no register byte read back as zero.

The register file occupies a 16-byte address space. The mapped bytes are:

| Byte address | Content |
|---|---|
| 0x0 | Configuration register (width field) |
| 0x4 to 0x7 | Four-byte register |
| 0x8 to 0x9 | Two-byte register |
| 0xC | One-byte register |

Register byte k of each register lives at its base address plus k. All other addresses are unmapped.

Top module: `regport_top`

## Requirements
- R1: While `rst_n` is low, the port captures `endian_strap`: low selects little endian, high selects big endian. Changes on the strap after reset is released have no effect on lane placement.
- R2: In little endian mode, the byte at position j of an access (j = 0 .. width-1) travels on bus bits 8j+7 down to 8j.
- R3: In big endian mode, position j travels on bits 31-8j down to 24-8j. In 8-bit mode, position 0 uses bits 31:24. In 16-bit mode, position 1 uses bits 23:16.
- R4: After reset, the port width is 8 bits and every register byte reads as zero.
- R5: Bits 1:0 of the byte at address 0x0 set the width: 00 selects 8 bits, 01 selects 16 bits, 10 selects 32 bits. A write of 11 leaves the width unchanged. Bits 7:2 read as zero. A new width applies from the next access.
- R6: An access at address A with a width of W bytes covers byte addresses B to B+W-1, where B is A rounded down to a multiple of W. Position j carries byte address B+j.
- R7: With an 8-bit port, the four-byte register needs four accesses, at 0x4, 0x5, 0x6 and 0x7. With a 16-bit port it needs two, at 0x4 and 0x6.
- R8: A write changes only the register bytes inside its group. All other bytes keep their values, so a partly completed multi-access write leaves the remaining bytes untouched.
- R9: On reads, lanes outside the active width return zero, and so do lanes whose byte address is unmapped. Writes to unmapped addresses, and write data on inactive lanes, have no effect.
- R10: `host_rdata` carries data, and `host_rdata_oe` is high, only while `host_cs` and `host_rd` are both high. At all other times both outputs are zero.
- R11: A write takes place at a rising clock edge only when `host_cs` and `host_wr` are both high. A write strobe without chip select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is captured while low |
| endian_strap | input | 1 | Static byte-order select (0 little, 1 big) |
| host_cs | input | 1 | Chip select |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | ADDR_W (4) | Host byte address |
| host_wdata | input | DATA_W (32) | Host write data, all lanes |
| host_rdata | output | DATA_W (32) | Host read data, zero when not reading |
| host_rdata_oe | output | 1 | Read data output enable |

## Verification
The bench builds the block with its default values: a 32-bit bus and a 4-bit address, which gives a 16-byte space. With a space this small, every byte address can be read back in each of the six width and endian combinations. Each combination writes every access group of all three sample registers, using patterns derived from the combination. A partial multi-access write and writes to unmapped addresses then probe byte retention and zero fill. Further steps rewrite the width field with the reserved code, toggle the strap after reset, and strobe the write line without chip select.

// File: rtl/regport_pkg.sv
`timescale 1ns/1ps
package regport_pkg;

    typedef enum logic [1:0] {
        PW_8  = 2'b00,
        PW_16 = 2'b01,
        PW_32 = 2'b10
    } pwidth_e;

    localparam int unsigned CFG_ADDR = 0;
    localparam int unsigned R32_BASE = 4;
    localparam int unsigned R16_BASE = 8;
    localparam int unsigned R8_BASE  = 12;

    // Number of bytes moved per access for a width code.
    function automatic int unsigned width_bytes(input logic [1:0] code);
        case (code)
            PW_8:    width_bytes = 1;
            PW_16:   width_bytes = 2;
            default: width_bytes = 4;
        endcase
    endfunction

    // True when a byte address holds storage.
    function automatic logic byte_mapped(input int unsigned a);
        byte_mapped = (a == CFG_ADDR)
                   || (a >= R32_BASE && a < R32_BASE + 4)
                   || (a >= R16_BASE && a < R16_BASE + 2)
                   || (a == R8_BASE);
    endfunction

endpackage

// File: rtl/regport_lanes.sv
`timescale 1ns/1ps
module regport_lanes
    import regport_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic [1:0]                   width,
    input  logic                         big_end,
    input  logic [ADDR_W-1:0]            addr,
    output logic [LANES-1:0]             lane_vld,
    output logic [LANES-1:0][ADDR_W-1:0] lane_addr
);

    int unsigned       nbytes;
    logic [ADDR_W-1:0] grp_mask;
    logic [ADDR_W-1:0] grp_base;

    always_comb begin
        nbytes   = width_bytes(width);
        grp_mask = ADDR_W'(nbytes - 1);
        grp_base = addr & ~grp_mask;
        for (int L = 0; L < LANES; L++) begin
            int pos;
            pos = big_end ? (LANES - 1 - L) : L;
            lane_vld[L]  = (pos < int'(nbytes));
            lane_addr[L] = lane_vld[L] ? (grp_base + ADDR_W'(pos)) : '0;
        end
    end

endmodule

// File: rtl/regport_bank.sv
`timescale 1ns/1ps
module regport_bank
    import regport_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [LANES-1:0]             lane_vld,
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES*8-1:0]           wdata,
    output logic [LANES*8-1:0]           rdata_raw,
    output logic [1:0]                   width_q
);

    localparam int NB = 1 << ADDR_W;

    typedef struct packed {
        logic [NB-1:0][7:0] mem;
    } bank_s;

    bank_s              st_d, st_q;
    logic [NB-1:0]      we;
    logic [NB-1:0][7:0] wbyte;

    always_comb begin
        st_d  = st_q;
        we    = '0;
        wbyte = '0;
        for (int b = 0; b < NB; b++) begin
            for (int L = 0; L < LANES; L++) begin
                if (wr_en && lane_vld[L] && lane_addr[L] == ADDR_W'(b)) begin
                    we[b]    = 1'b1;
                    wbyte[b] = wdata[8*L +: 8];
                end
            end
            if (we[b] && byte_mapped(b)) begin
                if (b == CFG_ADDR) begin
                    if (wbyte[b][1:0] != 2'b11)
                        st_d.mem[b] = {6'b0, wbyte[b][1:0]};
                end else begin
                    st_d.mem[b] = wbyte[b];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int L = 0; L < LANES; L++) begin
            if (lane_vld[L] && byte_mapped(int'(lane_addr[L])))
                rdata_raw[8*L +: 8] = st_q.mem[lane_addr[L]];
            else
                rdata_raw[8*L +: 8] = 8'h00;
        end
    end

    assign width_q = st_q.mem[CFG_ADDR][1:0];

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        width_q != 2'b11); // R5

    for (genvar gb = 0; gb < NB; gb++) begin : g_hold
        AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !we[gb] |=> $stable(st_q.mem[gb])); // R8
    end

endmodule

// File: rtl/regport_top.sv
`timescale 1ns/1ps
module regport_top
    import regport_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              endian_strap,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_oe
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic big_end;
    } top_s;

    top_s                         top_d, top_q;
    logic [1:0]                   width_q;
    logic [LANES-1:0]             lane_vld;
    logic [LANES-1:0][ADDR_W-1:0] lane_addr;
    logic [DATA_W-1:0]            rdata_raw;
    logic                         rd_act;
    logic                         wr_en;

    // Strap is sampled only while reset is held.
    always_comb begin
        top_d = top_q;
        if (!rst_n) top_d.big_end = endian_strap;
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    assign rd_act = host_cs & host_rd;
    assign wr_en  = host_cs & host_wr;

    regport_lanes #(.ADDR_W(ADDR_W), .LANES(LANES)) lanes_i (
        .width     (width_q),
        .big_end   (top_q.big_end),
        .addr      (host_addr),
        .lane_vld  (lane_vld),
        .lane_addr (lane_addr)
    );

    regport_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .lane_vld  (lane_vld),
        .lane_addr (lane_addr),
        .wdata     (host_wdata),
        .rdata_raw (rdata_raw),
        .width_q   (width_q)
    );

    assign host_rdata    = rd_act ? rdata_raw : '0;
    assign host_rdata_oe = rd_act;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cs && host_rd) |-> (host_rdata == '0 && !host_rdata_oe)); // R10

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(top_q.big_end)); // R1

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_vld) == int'(width_bytes(width_q))); // R6

    AST_LE_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !top_q.big_end |-> lane_vld[0]); // R2

    AST_BE_TOP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.big_end |-> lane_vld[LANES-1]); // R3

endmodule

// File: tb/regport_top_tb.sv
`timescale 1ns/1ps
module regport_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        endian_strap = 1'b0;
    logic        host_cs = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rdata_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench-side model
    logic [7:0] mdl_mem [16];
    int         mdl_w;      // width code 0,1,2
    int         mdl_be;

    always #5 clk = ~clk;

    regport_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .endian_strap  (endian_strap),
        .host_cs       (host_cs),
        .host_rd       (host_rd),
        .host_wr       (host_wr),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .host_rdata_oe (host_rdata_oe)
    );

    function automatic int nb_of(int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    function automatic bit mapped(int a);
        return (a == 0) || (a >= 4 && a < 8) || (a == 8) || (a == 9) || (a == 12);
    endfunction

    function automatic logic [7:0] mdl_byte(int a);
        if (a == 0) return 8'(mdl_w);
        if (mapped(a)) return mdl_mem[a];
        return 8'h00;
    endfunction

    function automatic logic [31:0] expect_rd(int a);
        logic [31:0] v;
        int nb, base;
        v = '0;
        nb = nb_of(mdl_w);
        base = a & ~(nb - 1);
        for (int L = 0; L < 4; L++) begin
            int j;
            j = mdl_be ? 3 - L : L;
            if (j < nb) v[8*L +: 8] = mdl_byte(base + j);
        end
        return v;
    endfunction

    task automatic check(string tag, int a, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0h actual=%h expected=%h", tag, a, act, exp);
        end
    endtask

    task automatic do_reset(int s);
        rst_n = 1'b0;
        endian_strap = 1'(s);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mdl_w = 0;
        mdl_be = s;
        for (int i = 0; i < 16; i++) mdl_mem[i] = 8'h00;
    endtask

    // posdata byte j is the byte for access position j
    task automatic do_write(int a, logic [31:0] posdata, bit use_cs);
        int nb, base;
        logic [31:0] wd;
        nb = nb_of(mdl_w);
        base = a & ~(nb - 1);
        for (int L = 0; L < 4; L++) begin
            int j;
            j = mdl_be ? 3 - L : L;
            wd[8*L +: 8] = (j < nb) ? posdata[8*j +: 8] : 8'hA5;  // junk on idle lanes
        end
        @(negedge clk);
        host_cs = use_cs; host_wr = 1'b1; host_rd = 1'b0;
        host_addr = 4'(a); host_wdata = wd;
        @(posedge clk);
        #1 host_cs = 1'b0; host_wr = 1'b0;
        if (use_cs) begin
            int w_new;
            w_new = mdl_w;
            for (int j = 0; j < nb; j++) begin
                int ba;
                ba = base + j;
                if (ba == 0) begin
                    if (posdata[1:0] != 2'b11) w_new = int'(posdata[1:0]);
                end else if (mapped(ba)) begin
                    mdl_mem[ba] = posdata[8*j +: 8];
                end
            end
            mdl_w = w_new;
        end
    endtask

    task automatic do_read(int a, string tag);
        @(negedge clk);
        host_cs = 1'b1; host_rd = 1'b1; host_wr = 1'b0; host_addr = 4'(a);
        #2;
        check(tag, a, host_rdata, expect_rd(a));
        check({tag, " R10 oe"}, a, {31'b0, host_rdata_oe}, 32'd1);
        host_cs = 1'b0; host_rd = 1'b0;
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < 16; a++) do_read(a, tag);
    endtask

    function automatic logic [31:0] pat(int s, int w, int a);
        logic [31:0] p;
        for (int j = 0; j < 4; j++) p[8*j +: 8] = 8'((a * 37 + w * 71 + s * 113 + j * 5 + 3));
        return p;
    endfunction

    task automatic write_groups(int s, int w, int first, int last);
        int nb;
        nb = nb_of(mdl_w);
        for (int a = first; a <= last; a += nb) do_write(a, pat(s, w, a), 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            do_reset(s);
            read_all(s ? "R4 reset R3" : "R4 reset R2");
            for (int w = 0; w < 3; w++) begin
                // R5: program width, takes effect next access
                do_write(0, {24'h0, 8'hFC | 8'(w)}, 1'b1);
                read_all("R5 cfg");
                // R6 R7: fill each register group by group
                write_groups(s, w, 4, 7);
                write_groups(s, w, 8, 9);
                write_groups(s, w, 12, 12);
                // R9: unmapped addresses ignore writes
                do_write(13, 32'hDEADBEEF, 1'b1);
                do_write(2, 32'hCAFEF00D, 1'b1);
                read_all(s ? "R3 R6 R7 R9 lanes" : "R2 R6 R7 R9 lanes");
                // R8: only the first group of the wide register
                do_write(4, ~pat(s, w, 4), 1'b1);
                read_all("R8 partial");
                // R10: idle and write-only cycles keep outputs quiet
                @(negedge clk);
                host_cs = 1'b1; host_rd = 1'b0; host_addr = 4'd4;
                #2 check("R10 idle data", 4, host_rdata, 32'h0);
                check("R10 idle oe", 4, {31'b0, host_rdata_oe}, 32'h0);
                host_rd = 1'b1; host_cs = 1'b0;
                #1 check("R10 no cs", 4, host_rdata, 32'h0);
                host_rd = 1'b0;
            end
            // R5: reserved code leaves width as is
            do_write(0, 32'hFFFF_FF03, 1'b1);
            read_all("R5 reserved");
            // R11: write strobe without chip select
            do_write(4, 32'h1234_5678, 1'b0);
            do_write(12, 32'h0000_0099, 1'b0);
            read_all("R11 no cs");
            // R1: strap flip after reset is ignored
            endian_strap = ~endian_strap;
            repeat (2) @(posedge clk);
            read_all("R1 strap");
            do_write(8, 32'h0BAD_F00D, 1'b1);
            read_all("R1 strap write");
            endian_strap = 1'(s);
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule